// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps track of a circular list of receive descriptors stored in a small on-block descriptor memory. Each descriptor has four 16-bit halfwords: a status word, a length word and two halfwords for a buffer pointer. The receive path signals a finished frame with a one-cycle pulse that carries the byte count and a set of error flags. The engine then fills the current descriptor and hands it to the host by clearing its empty flag. After that it moves to the next descriptor. The buffer pointer halfwords belong to the host and the engine never touches them. Payload data is not handled here.

The host prepares the ring through the halfword-wide descriptor port. It marks each descriptor it gives to hardware with the empty flag and sets a wrap flag on the last one. It also programs the index of the first descriptor through a small control port. When the engine meets a descriptor the host has not yet returned, it raises a busy event and stops. It stays stopped until the host explicitly releases it. Every frame that cannot be stored is counted.

Top module: `rxbd_ring`

## Requirements
- R1: The empty flag is status bit 15. A descriptor whose status has bit 15 clear is never written by the engine, and a frame that finds such a descriptor is not stored anywhere.
- R2: After a descriptor is filled, the engine moves to index+1 (modulo ring memory size). If the filled descriptor had its wrap flag (status bit 13) set, the engine moves to the programmed base index instead.
- R3: The length halfword (select 1) of a filled descriptor holds the frame's byte count plus 4 for the frame check sequence.
- R4: The status written to a filled descriptor has bit 15 clear and bits [ERR_W-1:0] equal to the frame's error flags. All other status bits, including wrap, keep the value the host left there.
- R5: A frame that meets a non-empty descriptor sets the busy event (`evt_busy`) and the halted state (`rx_halted`). Both are 0 after reset.
- R6: The halted state persists until a control write to address 2 with data bit 0 set. Frames arriving while halted leave the ring untouched. After release, the next frame goes to the same descriptor that caused the halt.
- R7: The busy event is cleared only by a control write to address 1 with data bit 0 set. A write with bit 0 clear leaves it set.
- R8: A control write to address 0 sets the base index. When `rx_en` rises, the current index is loaded from the base index.
- R9: `drop_cnt` increases by one for every enabled frame that is not stored. This covers frames arriving while halted, frames arriving while a previous frame is still being processed, and frames that meet a non-empty descriptor.
- R10: Descriptor port address = {index, select}. Select 0 is status, 1 is length, 2 and 3 are the pointer halves. Read data appears one cycle after the address. A host write in the same cycle as an engine write wins, and the engine waits.
- R11: Frame pulses while `rx_en` is low are ignored: no descriptor write and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; rising edge reloads the ring index |
| frm_valid | input | 1 | One-cycle frame-complete pulse |
| frm_len | input | DATA_W | Frame byte count without check sequence |
| frm_err | input | ERR_W | Frame error flags, zero for a good frame |
| host_we | input | 1 | Descriptor memory write strobe |
| host_addr | input | IDX_W+2 | Descriptor memory halfword address |
| host_wdata | input | DATA_W | Descriptor memory write data |
| host_rdata | output | DATA_W | Descriptor memory read data, one cycle latency |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 2 | Control register address (0 base, 1 event, 2 release) |
| ctl_wdata | input | IDX_W | Control register write data |
| evt_busy | output | 1 | Busy event, write-one-to-clear |
| rx_halted | output | 1 | Receive halted state |
| drop_cnt | output | CNT_W | Count of frames not stored |

## Verification
The hardest situation to reach is the full ring followed by recovery. The stimulus fills every descriptor up to the wrap flag so the engine lands on a descriptor the host has not returned. Further frames then arrive during the halt. The bench returns that descriptor before releasing the halt, so the resumed frame must land on exactly that index. The wrap-to-base check also needs care. It moves the base away from zero and returns descriptor 0 beforehand, so a wrong wrap to index 0 would be visible as a stored frame instead of a halt.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int SEL_W     = 2;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LEN  = 2'd1;
  localparam int EMPTY_BIT = 15;
  localparam int WRAP_BIT  = 13;
  localparam int FCS_BYTES = 4;
  localparam logic [1:0] REG_BASE  = 2'd0;
  localparam logic [1:0] REG_EVT   = 2'd1;
  localparam logic [1:0] REG_RSTAT = 2'd2;
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_WLEN, S_WST} eng_state_t;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/rxr_ctl_regs.sv
module rxr_ctl_regs #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_addr,
  input  logic [IDX_W-1:0] ctl_wdata,
  input  logic             halt_set,
  input  logic [1:0]       drop_n,
  output logic [IDX_W-1:0] base_q,
  output logic             busy_q,
  output logic             halted_q,
  output logic [CNT_W-1:0] drop_cnt_q
);
  import rxr_pkg::*;

  logic clr_busy, clr_halt;
  assign clr_busy = ctl_we && (ctl_addr == REG_EVT)   && ctl_wdata[0];
  assign clr_halt = ctl_we && (ctl_addr == REG_RSTAT) && ctl_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      busy_q     <= 1'b0;
      halted_q   <= 1'b0;
      drop_cnt_q <= '0;
    end else begin
      if (ctl_we && ctl_addr == REG_BASE) base_q <= ctl_wdata;
      if (halt_set)      busy_q <= 1'b1;
      else if (clr_busy) busy_q <= 1'b0;
      if (halt_set)      halted_q <= 1'b1;
      else if (clr_halt) halted_q <= 1'b0;
      drop_cnt_q <= drop_cnt_q + CNT_W'(drop_n);
    end
  end

  // R6: halted holds until an explicit release write
  p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !clr_halt) |=> halted_q);
  // R7: busy only leaves through a write-one clear
  p_busy_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !clr_busy) |=> busy_q);
  // R9: counter only moves when a frame is dropped
  p_drop_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (drop_n == 2'd0) |=> $stable(drop_cnt_q));
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
  parameter int IDX_W = 3,
  parameter int DATA_W = 16,
  parameter int ERR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rx_en,
  input  logic                      frm_valid,
  input  logic [DATA_W-1:0]         frm_len,
  input  logic [ERR_W-1:0]          frm_err,
  input  logic                      host_we,
  input  logic                      halted,
  input  logic [IDX_W-1:0]          base,
  input  logic [DATA_W-1:0]         rd_q,
  output logic [IDX_W+1:0]          eng_raddr,
  output logic                      eng_we,
  output logic [IDX_W+1:0]          eng_waddr,
  output logic [DATA_W-1:0]         eng_wdata,
  output logic                      halt_set,
  output logic [1:0]                drop_n
);
  import rxr_pkg::*;

  eng_state_t        state;
  logic [IDX_W-1:0]  cur_idx;
  logic              en_d;
  logic [DATA_W-1:0] len_q;
  logic [ERR_W-1:0]  err_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] stat_new;
  logic              late_drop;
  logic              wr_slot;

  assign wr_slot = rx_en && !host_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cur_idx <= '0;
      en_d    <= 1'b0;
      len_q   <= '0;
      err_q   <= '0;
      stat_q  <= '0;
    end else begin
      en_d <= rx_en;
      if (rx_en && !en_d) cur_idx <= base;
      if (!rx_en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (frm_valid && !halted) begin
            len_q <= frm_len + DATA_W'(FCS_BYTES);
            err_q <= frm_err;
            state <= S_RD;
          end
          S_RD:  state <= S_CHK;
          S_CHK: begin
            if (rd_q[EMPTY_BIT]) begin
              stat_q <= rd_q;
              state  <= S_WLEN;
            end else begin
              state  <= S_IDLE;
            end
          end
          S_WLEN: if (!host_we) state <= S_WST;
          S_WST: if (!host_we) begin
            state   <= S_IDLE;
            cur_idx <= stat_q[WRAP_BIT] ? base : cur_idx + 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stat_new              = stat_q;
    stat_new[EMPTY_BIT]   = 1'b0;
    stat_new[ERR_W-1:0]   = err_q;
  end

  assign eng_raddr = {cur_idx, SEL_STAT};
  assign eng_we    = wr_slot && (state == S_WLEN || state == S_WST);
  assign eng_waddr = {cur_idx, (state == S_WLEN) ? SEL_LEN : SEL_STAT};
  assign eng_wdata = (state == S_WLEN) ? len_q : stat_new;
  assign halt_set  = rx_en && (state == S_CHK) && !rd_q[EMPTY_BIT];
  assign late_drop = frm_valid && rx_en && (state != S_IDLE || halted);
  assign drop_n    = {1'b0, late_drop} + {1'b0, halt_set};

  // R1: a descriptor found owned by the host is never written
  p_owned_skip_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_CHK && rx_en && !rd_q[EMPTY_BIT]) |=> !eng_we);
  // R2: a wrap-flagged fill returns to the base index
  p_wrap_base_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_WST && wr_slot && stat_q[WRAP_BIT]) |=> cur_idx == $past(base));
  // R6: no descriptor traffic while halted
  p_quiet_halt_r6: assert property (@(posedge clk) disable iff (rst)
    halted |-> !eng_we);
  // R8: enabling restarts the ring at base
  p_enable_base_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |=> cur_idx == $past(base));
  // R10: engine yields the write port to the host
  p_host_wins_r10: assert property (@(posedge clk) disable iff (rst)
    host_we |-> !eng_we);
endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  parameter int ERR_W  = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              frm_valid,
  input  logic [DATA_W-1:0] frm_len,
  input  logic [ERR_W-1:0]  frm_err,
  input  logic              host_we,
  input  logic [IDX_W+1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_addr,
  input  logic [IDX_W-1:0]  ctl_wdata,
  output logic              evt_busy,
  output logic              rx_halted,
  output logic [CNT_W-1:0]  drop_cnt
);
  localparam int AW = IDX_W + 2;

  logic [IDX_W-1:0]  base_q;
  logic [DATA_W-1:0] eng_q;
  logic [AW-1:0]     eng_raddr, eng_waddr, m_waddr;
  logic              eng_we, m_we, halt_set;
  logic [DATA_W-1:0] eng_wdata, m_wdata;
  logic [1:0]        drop_n;

  assign m_we    = host_we || eng_we;
  assign m_waddr = host_we ? host_addr  : eng_waddr;
  assign m_wdata = host_we ? host_wdata : eng_wdata;

  rxr_desc_mem #(.AW(AW), .DW(DATA_W)) u_mem (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .raddr_a(host_addr), .rdata_a(host_rdata),
    .raddr_b(eng_raddr), .rdata_b(eng_q)
  );

  rxr_engine #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ERR_W(ERR_W)) u_eng (
    .clk(clk), .rst(rst), .rx_en(rx_en), .frm_valid(frm_valid),
    .frm_len(frm_len), .frm_err(frm_err), .host_we(host_we),
    .halted(rx_halted), .base(base_q), .rd_q(eng_q),
    .eng_raddr(eng_raddr), .eng_we(eng_we), .eng_waddr(eng_waddr),
    .eng_wdata(eng_wdata), .halt_set(halt_set), .drop_n(drop_n)
  );

  rxr_ctl_regs #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .halt_set(halt_set), .drop_n(drop_n),
    .base_q(base_q), .busy_q(evt_busy), .halted_q(rx_halted),
    .drop_cnt_q(drop_cnt)
  );
endmodule

// File: tb/test_rxbd_ring.sv
module test_rxbd_ring;
  localparam int IDX_W = 3, DATA_W = 16, ERR_W = 6, CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, frm_valid = 1'b0, host_we = 1'b0, ctl_we = 1'b0;
  logic [DATA_W-1:0] frm_len = '0, host_wdata = '0, host_rdata;
  logic [ERR_W-1:0]  frm_err = '0;
  logic [IDX_W+1:0]  host_addr = '0;
  logic [1:0]        ctl_addr = '0;
  logic [IDX_W-1:0]  ctl_wdata = '0;
  logic evt_busy, rx_halted;
  logic [CNT_W-1:0] drop_cnt;

  always #4 clk = ~clk;

  rxbd_ring #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ERR_W(ERR_W), .CNT_W(CNT_W)) i_rxbd_ring (
    .clk(clk), .rst(rst), .rx_en(rx_en), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_err(frm_err), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ctl_we(ctl_we),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .evt_busy(evt_busy),
    .rx_halted(rx_halted), .drop_cnt(drop_cnt)
  );

  typedef struct { int idx; logic [15:0] len; logic [15:0] st; string req; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic hwr(input int idx, input int sel, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = (IDX_W+2)'(idx*4 + sel); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hrd(input int idx, input int sel, output logic [15:0] d);
    @(negedge clk);
    host_addr = (IDX_W+2)'(idx*4 + sel);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic cwr(input logic [1:0] a, input int d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_addr = a; ctl_wdata = IDX_W'(d);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic pulse(input int len, input int err);
    @(negedge clk);
    frm_valid = 1'b1; frm_len = DATA_W'(len); frm_err = ERR_W'(err);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // driver: sends a frame and records what the ring must contain
  task automatic send(input int len, input int err, input int idx, input logic [15:0] st, input string req);
    exp_t e;
    pulse(len, err);
    repeat (8) @(negedge clk);
    e.idx = idx; e.len = 16'(len + 4); e.st = st; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: pops expectations and compares against the descriptor memory
  task automatic drain();
    logic [15:0] d;
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      hrd(e.idx, 1, d); chk(e.req, $sformatf("len of desc %0d", e.idx), 32'(d), 32'(e.len));
      hrd(e.idx, 0, d); chk(e.req, $sformatf("status of desc %0d", e.idx), 32'(d), 32'(e.st));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R5", "busy after reset", 32'(evt_busy), 0);
    chk("R5", "halted after reset", 32'(rx_halted), 0);
    chk("R9", "drops after reset", 32'(drop_cnt), 0);

    // R10: host port write and readback of a pointer half
    hwr(6, 2, 16'h1234);
    hrd(6, 2, d); chk("R10", "pointer readback", 32'(d), 32'h1234);

    cwr(2'd0, 0);
    hwr(0, 0, 16'h8000); hwr(1, 0, 16'h8000); hwr(2, 0, 16'h8400); hwr(3, 0, 16'hA000);
    @(negedge clk); rx_en = 1'b1;

    send(60,   0,    0, 16'h0000, "R3");
    send(100,  5,    1, 16'h0005, "R4");
    send(1514, 6'h3F, 2, 16'h043F, "R4");
    send(46,   2,    3, 16'h2002, "R2");
    drain();
    chk("R9", "no drops on good ring", 32'(drop_cnt), 0);

    // ring exhausted: desc 0 still host-owned
    pulse(70, 0); repeat (8) @(negedge clk);
    chk("R5", "busy on full ring", 32'(evt_busy), 1);
    chk("R5", "halted on full ring", 32'(rx_halted), 1);
    chk("R9", "drop on full ring", 32'(drop_cnt), 1);
    sb.push_back('{0, 16'd64, 16'h0000, "R1"});
    drain();

    pulse(80, 1); repeat (8) @(negedge clk);
    chk("R9", "drop while halted", 32'(drop_cnt), 2);
    cwr(2'd1, 0);
    chk("R7", "busy kept on zero write", 32'(evt_busy), 1);
    cwr(2'd1, 1);
    chk("R7", "busy cleared", 32'(evt_busy), 0);
    chk("R6", "halt kept after event clear", 32'(rx_halted), 1);

    hwr(0, 0, 16'h8000);
    pulse(90, 0); repeat (8) @(negedge clk);
    hrd(0, 0, d); chk("R6", "ring untouched while halted", 32'(d), 32'h8000);
    chk("R9", "drop while halted again", 32'(drop_cnt), 3);
    cwr(2'd2, 1);
    chk("R6", "halt released", 32'(rx_halted), 0);
    send(200, 0, 0, 16'h0000, "R6");
    drain();

    // back-to-back frames: second one arrives mid-processing
    hwr(1, 0, 16'h8000); hwr(2, 0, 16'h8400);
    pulse(300, 0); pulse(400, 0); repeat (10) @(negedge clk);
    sb.push_back('{1, 16'd304, 16'h0000, "R9"});
    drain();
    hrd(2, 0, d); chk("R9", "overlapping frame not stored", 32'(d), 32'h8400);
    chk("R9", "overlap counted", 32'(drop_cnt), 4);

    // disabled: frame ignored
    @(negedge clk); rx_en = 1'b0;
    pulse(50, 0); repeat (8) @(negedge clk);
    hrd(2, 0, d); chk("R11", "no write while disabled", 32'(d), 32'h8400);
    chk("R11", "no count while disabled", 32'(drop_cnt), 4);

    // new base, wrap returns to base not to zero
    cwr(2'd0, 4);
    hwr(4, 0, 16'h8000); hwr(5, 0, 16'hA000); hwr(0, 0, 16'h8000);
    @(negedge clk); rx_en = 1'b1;
    send(80, 0, 4, 16'h0000, "R8");
    send(90, 1, 5, 16'h2001, "R2");
    drain();
    pulse(10, 0); repeat (8) @(negedge clk);
    chk("R2", "wrap lands on base (halt)", 32'(rx_halted), 1);
    hrd(0, 0, d); chk("R2", "index 0 not used after wrap", 32'(d), 32'h8000);
    chk("R1", "host-owned base left alone", 32'(drop_cnt), 5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule